// File: doc/BRIEF.md
# Console Terminal Character I/O Port

This block is the programmed-I/O side of a console terminal. It pairs a keyboard receiver and a printer transmitter on a CPU I/O transfer bus. When the CPU runs an I/O transfer instruction it raises an execute strobe and presents the 12-bit instruction word and the accumulator. The block decodes the word. The top three bits must be 110. Bits 8..3 select the device: octal 03 is the keyboard and octal 04 is the printer. Bits 2..0 form an operation field. The block answers in the same cycle with a skip request, an accumulator-clear request and a word to OR into the accumulator.

Each of the three operation bits triggers one action. When several bits are set, the actions apply from the lowest bit to the highest. Bit 0 tests the device flag, so a skip decision sees the flag as it was before a clear in the same instruction takes effect. The ready flags are set by events on the device side: a received byte, or a transmit-done strobe. They are never set by the CPU. The OR of the two flags drives the interrupt request. The printer flag is clear after reset, so software sends a first character to start the output handshake.

Top module: `con_tty_io`

## Requirements
- R1: Outputs are driven only when `iot_exec` is high, bits 11..9 of `iot_word` equal 3'b110 and bits 8..3 equal 6'o03 (keyboard) or 6'o04 (printer). In every other case `skip_req`, `ac_clr_req` and `ac_or_data` are zero and no flag or buffer changes.
- R2: Keyboard operation bit 0 (value 1) drives `skip_req` high in the same cycle exactly when the keyboard flag is set.
- R3: Keyboard operation bit 1 (value 2) drives `ac_clr_req` high in the same cycle and clears the keyboard flag at the clock edge.
- R4: Keyboard operation bit 2 (value 4) drives `ac_or_data` to the received byte, zero-extended, in the same cycle. Code 6 therefore yields both the clear and the byte, so the resulting AC is {4'b0, byte}.
- R5: `rx_valid` loads `rx_byte` into the receive buffer and sets the keyboard flag at the clock edge. A byte that arrives while the flag is already set overwrites the buffer and the flag stays set.
- R6: Printer operation bit 0 (value 1) drives `skip_req` high in the same cycle exactly when the printer flag is set.
- R7: Printer operation bit 1 (value 2) clears the printer flag at the clock edge and does not raise `ac_clr_req`.
- R8: Printer operation bit 2 (value 4) makes `tx_start` high for exactly the following cycle, with `tx_byte` equal to bits 7..0 of `acc_in`. It also sets `tx_busy`, which stays high until `tx_done`.
- R9: The printer flag is zero after reset. `tx_done` sets the printer flag and clears `tx_busy` at the clock edge.
- R10: Printer code 6 clears the flag and then starts transmission. The flag stays clear, even while `tx_start` pulses, until `tx_done` arrives.
- R11: An operation field of 000 on either device has no effect.
- R12: `irq` is high whenever either ready flag is set.
- R13: Reset or `master_clr` clears both flags, `tx_busy` and `tx_start` at the clock edge.
- R14: A device event in the same cycle as a CPU flag clear wins: the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_clr | input | 1 | Synchronous clear of all flags and the transmit state |
| iot_exec | input | 1 | Execute strobe for the current I/O transfer instruction |
| iot_word | input | 12 | Instruction word: opcode, device, operation bits |
| acc_in | input | 12 | Accumulator value at execution |
| skip_req | output | 1 | Request to skip the next instruction |
| ac_clr_req | output | 1 | Request to clear the accumulator before the OR |
| ac_or_data | output | 12 | Data to OR into the accumulator |
| irq | output | 1 | Interrupt request, any flag set |
| rx_valid | input | 1 | Received byte valid strobe |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_start | output | 1 | One-cycle transmit start strobe |
| tx_busy | output | 1 | Transmission in progress |
| tx_done | input | 1 | Transmit completion strobe |

## Verification
The CPU-facing answers (`skip_req`, `ac_clr_req`, `ac_or_data`) are combinational and due in the cycle of the strobe. The bench drives at the falling edge and samples one nanosecond later, before the rising edge that commits state. Flags, `irq`, the receive buffer, `tx_start`, `tx_byte` and `tx_busy` change at that rising edge, and the bench reads them at the next falling edge. Each flag's state is also confirmed through a later skip-test instruction. `tx_start` is sampled in the single cycle after the print request and again one cycle later, to confirm it is a one-cycle pulse.

// File: rtl/con_tty_pkg.sv
package con_tty_pkg;

   localparam logic [2:0] OPC_IOT  = 3'b110;
   localparam int         OPB_TEST = 0;
   localparam int         OPB_CLR  = 1;
   localparam int         OPB_XFER = 2;

   typedef struct packed {
      logic test;
      logic clr;
      logic xfer;
   } iot_act_t;

endpackage

// File: rtl/con_tty_dec.sv
module con_tty_dec
   import con_tty_pkg::*;
#(
   parameter int             WORD_W = 12,
   parameter int             DEV_W  = 6,
   parameter logic [DEV_W-1:0] DEV_ID = 6'o03
) (
   input  logic              exec,
   input  logic [WORD_W-1:0] word,
   output iot_act_t          act
);
   localparam int OP_W = 3;

   initial begin
      assert (WORD_W == DEV_W + OP_W + 3)
         else $error("con_tty_dec: word width must hold opcode, device and op fields");
   end

   logic [2:0]       opc;
   logic [DEV_W-1:0] dev;
   logic [OP_W-1:0]  op;
   logic             sel;

   always_comb begin
      opc      = word[WORD_W-1 -: 3];
      dev      = word[OP_W +: DEV_W];
      op       = word[OP_W-1:0];
      sel      = exec && (opc == OPC_IOT) && (dev == DEV_ID);
      act.test = sel && op[OPB_TEST];
      act.clr  = sel && op[OPB_CLR];
      act.xfer = sel && op[OPB_XFER];
   end

endmodule

// File: rtl/con_tty_kbd.sv
module con_tty_kbd
   import con_tty_pkg::*;
#(
   parameter int WORD_W    = 12,
   parameter int BYTE_W    = 8,
   parameter bit OVERWRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_clr,
   input  iot_act_t          act,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              flag,
   output logic              skip,
   output logic              ac_clr,
   output logic [WORD_W-1:0] or_data
);
   initial begin
      assert (BYTE_W <= WORD_W)
         else $error("con_tty_kbd: byte wider than accumulator");
   end

   logic [BYTE_W-1:0] rbuf;
   logic              load;

   generate
      if (OVERWRITE) begin : g_ovw
         assign load = rx_valid;
      end else begin : g_keep
         assign load = rx_valid && (!flag || act.clr);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         rbuf <= '0;
      end else if (master_clr) begin
         flag <= 1'b0;
      end else begin
         if (load)
            rbuf <= rx_byte;
         if (rx_valid)
            flag <= 1'b1;
         else if (act.clr)
            flag <= 1'b0;
      end
   end

   always_comb begin
      skip    = act.test && flag;
      ac_clr  = act.clr;
      or_data = act.xfer ? {{(WORD_W-BYTE_W){1'b0}}, rbuf} : '0;
   end

   AST_RX_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !master_clr) |=> flag);                                   // R5
   AST_KBD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (act.clr && !rx_valid && !master_clr) |=> !flag);                      // R3
   AST_RX_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !master_clr && (OVERWRITE || !flag))
      |=> (rbuf == $past(rx_byte)));                                         // R5
   AST_CLR_WINS_NOT: assert property (@(posedge clk) disable iff (!rst_n)
      (act.clr && rx_valid && !master_clr) |=> flag);                        // R14

endmodule

// File: rtl/con_tty_prn.sv
module con_tty_prn
   import con_tty_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_clr,
   input  iot_act_t          act,
   input  logic [BYTE_W-1:0] acc_low,
   input  logic              tx_done,
   output logic              flag,
   output logic              skip,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_start,
   output logic              tx_busy
);
   initial begin
      assert (BYTE_W <= WORD_W)
         else $error("con_tty_prn: byte wider than accumulator");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag     <= 1'b0;
         tx_byte  <= '0;
         tx_start <= 1'b0;
         tx_busy  <= 1'b0;
      end else if (master_clr) begin
         flag     <= 1'b0;
         tx_start <= 1'b0;
         tx_busy  <= 1'b0;
      end else begin
         tx_start <= act.xfer;
         if (act.xfer)
            tx_byte <= acc_low;
         if (act.xfer)
            tx_busy <= 1'b1;
         else if (tx_done)
            tx_busy <= 1'b0;
         if (tx_done)
            flag <= 1'b1;
         else if (act.clr)
            flag <= 1'b0;
      end
   end

   assign skip = act.test && flag;

   AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (act.xfer && !master_clr) |=> (tx_start && tx_busy && tx_byte == $past(acc_low))); // R8
   AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!act.xfer) |=> !tx_start);                                            // R8
   AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !master_clr) |=> flag);                                    // R9
   AST_PRN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (act.clr && !tx_done && !master_clr) |=> !flag);                       // R7
   AST_FLAG_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !tx_done) |=> !flag);                                        // R10

endmodule

// File: rtl/con_tty_io.sv
module con_tty_io
   import con_tty_pkg::*;
#(
   parameter int             WORD_W    = 12,
   parameter int             BYTE_W    = 8,
   parameter int             DEV_W     = 6,
   parameter logic [DEV_W-1:0] KBD_DEV = 6'o03,
   parameter logic [DEV_W-1:0] PRN_DEV = 6'o04,
   parameter bit             RX_OVERWRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_clr,
   input  logic              iot_exec,
   input  logic [WORD_W-1:0] iot_word,
   input  logic [WORD_W-1:0] acc_in,
   output logic              skip_req,
   output logic              ac_clr_req,
   output logic [WORD_W-1:0] ac_or_data,
   output logic              irq,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_start,
   output logic              tx_busy,
   input  logic              tx_done
);
   localparam int NDEV = 2;
   localparam int KBD  = 0;
   localparam int PRN  = 1;

   initial begin
      assert (KBD_DEV != PRN_DEV)
         else $error("con_tty_io: keyboard and printer need distinct device codes");
      assert (BYTE_W > 0 && BYTE_W <= WORD_W)
         else $error("con_tty_io: bad byte width");
   end

   localparam logic [DEV_W-1:0] DEV_IDS [NDEV] = '{KBD_DEV, PRN_DEV};

   iot_act_t act [NDEV];

   generate
      for (genvar d = 0; d < NDEV; d++) begin : g_dec
         con_tty_dec #(.WORD_W(WORD_W), .DEV_W(DEV_W), .DEV_ID(DEV_IDS[d])) u_dec (
            .exec (iot_exec),
            .word (iot_word),
            .act  (act[d])
         );
      end
   endgenerate

   logic              kbd_flag, kbd_skip, kbd_clr;
   logic [WORD_W-1:0] kbd_or;
   logic              prn_flag, prn_skip;

   con_tty_kbd #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .OVERWRITE(RX_OVERWRITE)) u_kbd (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_clr (master_clr),
      .act        (act[KBD]),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_byte),
      .flag       (kbd_flag),
      .skip       (kbd_skip),
      .ac_clr     (kbd_clr),
      .or_data    (kbd_or)
   );

   con_tty_prn #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_prn (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_clr (master_clr),
      .act        (act[PRN]),
      .acc_low    (acc_in[BYTE_W-1:0]),
      .tx_done    (tx_done),
      .flag       (prn_flag),
      .skip       (prn_skip),
      .tx_byte    (tx_byte),
      .tx_start   (tx_start),
      .tx_busy    (tx_busy)
   );

   generate
      if (WORD_W > BYTE_W) begin : g_hi
         logic unused_acc_hi;
         assign unused_acc_hi = ^acc_in[WORD_W-1:BYTE_W];
      end
   endgenerate

   always_comb begin
      skip_req   = kbd_skip | prn_skip;
      ac_clr_req = kbd_clr;
      ac_or_data = kbd_or;
      irq        = kbd_flag | prn_flag;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !iot_exec |-> (!skip_req && !ac_clr_req && ac_or_data == '0));         // R1
   AST_MCLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      master_clr |=> (!irq && !tx_busy && !tx_start));                       // R13
   AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act[KBD].test | act[KBD].clr | act[KBD].xfer,
                act[PRN].test | act[PRN].clr | act[PRN].xfer}));             // R1

endmodule

// File: tb/sim_con_tty_io.sv
`timescale 1ns/1ps
module sim_con_tty_io;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_clr = 1'b0;
   logic        iot_exec = 1'b0;
   logic [11:0] iot_word = '0;
   logic [11:0] acc_in = '0;
   logic        skip_req, ac_clr_req, irq, tx_start, tx_busy;
   logic [11:0] ac_or_data;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic [7:0]  tx_byte;
   logic        tx_done = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic        s_skip, s_clr;
   logic [11:0] s_or;

   always #2.5 clk = ~clk;

   con_tty_io u0 (
      .clk(clk), .rst_n(rst_n), .master_clr(master_clr),
      .iot_exec(iot_exec), .iot_word(iot_word), .acc_in(acc_in),
      .skip_req(skip_req), .ac_clr_req(ac_clr_req), .ac_or_data(ac_or_data),
      .irq(irq), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .tx_byte(tx_byte), .tx_start(tx_start), .tx_busy(tx_busy), .tx_done(tx_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One cycle of stimulus; combinational answers captured before the edge.
   task automatic cyc(input logic [11:0] w, input logic [11:0] a, input bit ex = 1,
                      input bit rxv = 0, input logic [7:0] rxb = 0,
                      input bit txd = 0, input bit mc = 0);
      @(negedge clk);
      iot_exec = ex; iot_word = w; acc_in = a;
      rx_valid = rxv; rx_byte = rxb; tx_done = txd; master_clr = mc;
      #1;
      s_skip = skip_req; s_clr = ac_clr_req; s_or = ac_or_data;
      @(negedge clk);
      iot_exec = 0; iot_word = '0; acc_in = '0;
      rx_valid = 0; rx_byte = '0; tx_done = 0; master_clr = 0;
   endtask

   task automatic t_reset();
      chk("R9 irq after reset", irq, 0);
      chk("R13 tx_busy after reset", tx_busy, 0);
      chk("R13 tx_start after reset", tx_start, 0);
      cyc(12'o6041, 0);
      chk("R9 printer flag clear after reset", s_skip, 0);
   endtask

   task automatic t_kbd_read();
      cyc(0, 0, 0, 1, 8'hA5);
      chk("R5 rx sets flag irq", irq, 1);
      chk("R12 irq with keyboard flag", irq, 1);
      cyc(12'o6031, 0);
      chk("R2 skip on keyboard flag", s_skip, 1);
      cyc(12'o6034, 12'o7777);
      chk("R4 read data", s_or, 12'h0A5);
      chk("R4 read does not clear AC", s_clr, 0);
      cyc(12'o6036, 0);
      chk("R4 code6 clear request", s_clr, 1);
      chk("R4 code6 data", s_or, 12'h0A5);
      chk("R3 flag cleared irq", irq, 0);
      cyc(12'o6031, 0);
      chk("R2 no skip after clear", s_skip, 0);
   endtask

   task automatic t_kbd_overwrite();
      cyc(0, 0, 0, 1, 8'h11);
      cyc(0, 0, 0, 1, 8'h22);
      cyc(12'o6034, 0);
      chk("R5 overwrite keeps newest", s_or, 12'h022);
      cyc(12'o6031, 0);
      chk("R5 flag still set", s_skip, 1);
      cyc(12'o6032, 0, 1, 1, 8'h33);
      cyc(12'o6031, 0);
      chk("R14 arrival beats clear", s_skip, 1);
      cyc(12'o6034, 0);
      chk("R14 new byte stored", s_or, 12'h033);
      cyc(12'o6032, 0);
      cyc(12'o6031, 0);
      chk("R3 clear alone", s_skip, 0);
   endtask

   task automatic t_ignore();
      cyc(0, 0, 0, 1, 8'h44);
      cyc(12'o6030, 12'o7777);
      chk("R11 op000 skip", s_skip, 0);
      chk("R11 op000 clr", s_clr, 0);
      chk("R11 op000 data", s_or, 0);
      cyc(12'o6036, 0, 0);
      chk("R1 no exec no clr", s_clr, 0);
      cyc(12'o7036, 0);
      chk("R1 other opcode data", s_or, 0);
      cyc(12'o6056, 0);
      chk("R1 other device clr", s_clr, 0);
      cyc(12'o6031, 0);
      chk("R1 R11 flag untouched", s_skip, 1);
      cyc(12'o6032, 0);
   endtask

   task automatic t_print();
      cyc(12'o6044, 12'o7301);
      chk("R8 tx_start pulse", tx_start, 1);
      chk("R8 tx_byte low bits", tx_byte, 8'hC1);
      chk("R8 busy set", tx_busy, 1);
      cyc(12'o6041, 0);
      chk("R8 tx_start one cycle", tx_start, 0);
      chk("R6 no skip before done", s_skip, 0);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R9 done sets flag", irq, 1);
      chk("R9 done clears busy", tx_busy, 0);
      cyc(12'o6041, 0);
      chk("R6 skip on printer flag", s_skip, 1);
      cyc(12'o6046, 12'o0101);
      chk("R10 code6 starts", tx_start, 1);
      chk("R10 code6 byte", tx_byte, 8'h41);
      chk("R10 flag cleared", irq, 0);
      repeat (3) cyc(0, 0, 0);
      cyc(12'o6041, 0);
      chk("R10 flag held until done", s_skip, 0);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R10 done restores flag", irq, 1);
      cyc(12'o6042, 0, 1, 0, 0, 1);
      chk("R7 printer clear no AC clear", s_clr, 0);
      chk("R14 done beats clear", irq, 1);
      cyc(12'o6042, 0);
      chk("R7 printer clear", irq, 0);
   endtask

   task automatic t_mclr();
      cyc(0, 0, 0, 1, 8'h55);
      cyc(12'o6044, 12'o0052);
      cyc(0, 0, 0, 0, 0, 1);
      cyc(12'o6044, 12'o0053);
      chk("R12 both flags irq", irq, 1);
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk("R13 master clear irq", irq, 0);
      chk("R13 master clear busy", tx_busy, 0);
      chk("R13 master clear start", tx_start, 0);
      cyc(12'o6031, 0);
      chk("R13 keyboard flag cleared", s_skip, 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_kbd_read();
      t_kbd_overwrite();
      t_ignore();
      t_print();
      t_mclr();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule